// File: doc/BRIEF.md
# Pointing Device Command Sequencer

This block brings a serial pointing device out of power-up and into streaming operation. After an enable request it raises its request and ready strobes toward the device. Each rising edge on the device interrupt line then sends the next of four fixed command bytes to an external byte shifter. A byte is launched only while the device's active-low slave-enable status reads low. The edge that follows the last command ends initialisation: the request strobe drops, ready stays high, and a mode output tells downstream logic to treat further traffic as received packets.

Each completed step is acknowledged with a one-cycle interrupt-clear pulse, so one edge moves the sequence by exactly one step. A disable request tears everything down: both strobes go low, the link-enable output goes low and interrupt edges are no longer acted on. The external shifter is expected to be configured for 8-bit words, most significant bit first, idle-high clock, phase 0 and no gap between words. The shifter and any power management sit outside this block.

Top module: `ptr_cmd_seq`

## Requirements
- R1: After reset the block is off: link_on, req_o, rdy_o, rx_mode, tx_valid and irq_clr are all 0.
- R2: An enable request while off sets link_on, req_o and rdy_o to 1 and rx_mode to 0 one cycle later, and restarts the command index at the first command.
- R3: Commands leave on tx_byte, qualified by tx_valid, in the fixed order 0xF5, 0xF2, 0xF8, 0xF4, and only while initialising (link_on 1, rx_mode 0).
- R4: A byte requested by an interrupt edge is held back while sel_n is 1. It is launched (tx_valid 1) in the cycle after the first clock edge at which sel_n is sampled 0.
- R5: Each interrupt edge during initialisation produces at most one byte. tx_valid is a single-cycle pulse, and an edge that arrives while a byte is still held back is ignored.
- R6: The interrupt edge after the fourth byte sends no byte. It sets rx_mode to 1, req_o to 0 and rdy_o to 1, and pulses irq_clr.
- R7: A disable request sets link_on, req_o, rdy_o and rx_mode to 0 one cycle later. While off, interrupt edges produce no byte and no irq_clr pulse.
- R8: irq_clr pulses for exactly one cycle with every sent byte (same cycle as tx_valid) and with the switch to receive mode. During a send, req_o and rdy_o are 1.
- R9: An enable request while already on, or a disable request while already off, changes nothing: an interrupted sequence continues with its next byte.
- R10: When enable and disable requests arrive in the same cycle, disable wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_req | input | 1 | Enable request (one-cycle pulse) |
| dis_req | input | 1 | Disable request (one-cycle pulse) |
| dev_irq | input | 1 | Device interrupt, rising edge significant |
| sel_n | input | 1 | Active-low slave-enable status from the device |
| tx_valid | output | 1 | One-cycle strobe: tx_byte is to be shifted out |
| tx_byte | output | 8 | Command byte for the shifter |
| req_o | output | 1 | Request strobe to the device |
| rdy_o | output | 1 | Ready strobe to the device |
| link_on | output | 1 | Enables the external shifter |
| rx_mode | output | 1 | 1 once initialisation is done (receive mode) |
| irq_clr | output | 1 | One-cycle acknowledge of a handled interrupt |

## Verification
On every cycle the assertions check the strobe levels that belong to each phase, that a launch follows a low slave-enable sample, that tx_valid never lasts more than one cycle, that bytes appear only while initialising, and that disable takes effect at once and beats enable. The byte order, the counting of edges, edges ignored while a byte is held back, and a redundant enable or disable leaving the sequence where it was can only be shown by the bench's scenarios, which compare the bytes seen against the expected sequence.

// File: rtl/ptr_seq_pkg.sv
// Package: shared phase type and the fixed start-up command list.
// Assumes commands are DATA_W = 8 bits wide.
package ptr_seq_pkg;

    typedef enum logic [1:0] {
        PH_OFF    = 2'd0,
        PH_INIT   = 2'd1,
        PH_STREAM = 2'd2
    } phase_t;

    localparam int unsigned CMD_COUNT = 4;

    // Returns the start-up command at position idx (device order matters).
    function automatic logic [7:0] cmd_at(input int unsigned idx);
        case (idx)
            0:       return 8'hF5;
            1:       return 8'hF2;
            2:       return 8'hF8;
            default: return 8'hF4;
        endcase
    endfunction

endpackage

// File: rtl/ptr_edge_det.sv
// Module: rising-edge detector for the device interrupt line.
// Assumes the input is already synchronous to clk.
module ptr_edge_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_i,
    output logic rise_o
);
    logic sig_q;

    // Remember the previous sample of the line.
    always_ff @(posedge clk) begin
        if (!rst_n) sig_q <= 1'b0;
        else        sig_q <= sig_i;
    end

    assign rise_o = sig_i & ~sig_q;
endmodule

// File: rtl/ptr_cmd_rom.sv
// Module: maps the command index to a command byte.
// Assumes idx stays below NUM_CMDS whenever the byte is used.
module ptr_cmd_rom #(
    parameter int IDX_W  = 3,
    parameter int DATA_W = 8
) (
    input  logic [IDX_W-1:0]  idx,
    output logic [DATA_W-1:0] cmd
);
    // Combinational lookup in the package command list.
    always_comb begin
        cmd = DATA_W'(ptr_seq_pkg::cmd_at(32'(idx)));
    end
endmodule

// File: rtl/ptr_cmd_seq.sv
// Module: start-up command sequencer for a serial pointing device.
// Sends the fixed command list one byte per interrupt edge, gated by the
// active-low slave-enable status, then switches to receive mode.
// Assumes all inputs are synchronous to clk; en_req/dis_req are pulses.
module ptr_cmd_seq #(
    parameter int DATA_W   = 8,
    parameter int NUM_CMDS = ptr_seq_pkg::CMD_COUNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_req,
    input  logic              dis_req,
    input  logic              dev_irq,
    input  logic              sel_n,
    output logic              tx_valid,
    output logic [DATA_W-1:0] tx_byte,
    output logic              req_o,
    output logic              rdy_o,
    output logic              link_on,
    output logic              rx_mode,
    output logic              irq_clr
);
    import ptr_seq_pkg::*;

    localparam int IDX_W = $clog2(NUM_CMDS + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_CMDS);

    phase_t            phase;
    logic [IDX_W-1:0]  idx;
    logic              pend;
    logic              irq_rise;
    logic [DATA_W-1:0] cur_cmd;

    ptr_edge_det u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sig_i  (dev_irq),
        .rise_o (irq_rise)
    );

    ptr_cmd_rom #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_rom (
        .idx (idx),
        .cmd (cur_cmd)
    );

    // Phase, index, hold-back flag and strobes; disable has top priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= PH_OFF;
            idx      <= '0;
            pend     <= 1'b0;
            tx_valid <= 1'b0;
            tx_byte  <= '0;
            req_o    <= 1'b0;
            rdy_o    <= 1'b0;
            irq_clr  <= 1'b0;
        end else begin
            tx_valid <= 1'b0;
            irq_clr  <= 1'b0;
            if (dis_req) begin
                if (phase != PH_OFF) begin
                    phase <= PH_OFF;
                    idx   <= '0;
                    pend  <= 1'b0;
                    req_o <= 1'b0;
                    rdy_o <= 1'b0;
                end
            end else if (en_req && phase == PH_OFF) begin
                phase <= PH_INIT;
                idx   <= '0;
                pend  <= 1'b0;
                req_o <= 1'b1;
                rdy_o <= 1'b1;
            end else if (phase == PH_INIT) begin
                if (pend) begin
                    if (!sel_n) begin
                        tx_valid <= 1'b1;
                        tx_byte  <= cur_cmd;
                        idx      <= idx + 1'b1;
                        pend     <= 1'b0;
                        req_o    <= 1'b1;
                        rdy_o    <= 1'b1;
                        irq_clr  <= 1'b1;
                    end
                end else if (irq_rise) begin
                    if (idx == LAST_IDX) begin
                        phase   <= PH_STREAM;
                        idx     <= '0;
                        req_o   <= 1'b0;
                        rdy_o   <= 1'b1;
                        irq_clr <= 1'b1;
                    end else begin
                        pend <= 1'b1;
                    end
                end
            end
        end
    end

    assign link_on = (phase != PH_OFF);
    assign rx_mode = (phase == PH_STREAM);
endmodule

// File: rtl/ptr_cmd_seq_chk.sv
// Module: property checker for ptr_cmd_seq, attached by bind.
// Assumes the same clock and synchronous active-low reset as the block.
module ptr_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic en_req,
    input logic dis_req,
    input logic sel_n,
    input logic tx_valid,
    input logic req_o,
    input logic rdy_o,
    input logic link_on,
    input logic rx_mode
);
    AST_EN_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        (en_req && !dis_req && !link_on) |=> (link_on && req_o && rdy_o && !rx_mode)); // R2
    AST_TX_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (link_on && !rx_mode)); // R3
    AST_TX_AFTER_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> !$past(sel_n)); // R4
    AST_TX_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |=> !tx_valid); // R5
    AST_STREAM_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        rx_mode |-> (!req_o && rdy_o)); // R6
    AST_OFF_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        !link_on |-> (!req_o && !rdy_o && !rx_mode && !tx_valid)); // R7
    AST_TX_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> (req_o && rdy_o)); // R8
    AST_DIS_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        dis_req |=> !link_on); // R10
endmodule

bind ptr_cmd_seq ptr_cmd_seq_chk u_chk (.*);

// File: tb/ptr_cmd_seq_tb.sv
module ptr_cmd_seq_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en_req = 1'b0;
    logic       dis_req = 1'b0;
    logic       dev_irq = 1'b0;
    logic       sel_n = 1'b1;
    logic       tx_valid;
    logic [7:0] tx_byte;
    logic       req_o, rdy_o, link_on, rx_mode, irq_clr;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    ptr_cmd_seq u_dut (
        .clk(clk), .rst_n(rst_n), .en_req(en_req), .dis_req(dis_req),
        .dev_irq(dev_irq), .sel_n(sel_n), .tx_valid(tx_valid),
        .tx_byte(tx_byte), .req_o(req_o), .rdy_o(rdy_o),
        .link_on(link_on), .rx_mode(rx_mode), .irq_clr(irq_clr)
    );

    // {enable pulse first, cycles sel_n stays high, expected byte}
    localparam logic [15:0] STEPS [4] = '{
        {1'b0, 7'd0, 8'hF5},
        {1'b0, 7'd3, 8'hF2},
        {1'b1, 7'd1, 8'hF8},
        {1'b0, 7'd5, 8'hF4}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk) s = 1'b1;
        @(negedge clk) s = 1'b0;
    endtask

    // One edge, hold sel_n high for w cycles, then expect byte b.
    task automatic step(input int w, input logic [7:0] b);
        sel_n = 1'b1;
        @(negedge clk) dev_irq = 1'b1;
        @(negedge clk) dev_irq = 1'b0;
        for (int i = 0; i < w; i++) begin
            @(negedge clk);
            chk(tx_valid == 1'b0, "R4", "held while sel_n high", tx_valid, 0);
        end
        sel_n = 1'b0;
        @(negedge clk);
        chk(tx_valid == 1'b1 && tx_byte == b, "R3", "byte", tx_byte, b);
        chk(irq_clr && req_o && rdy_o, "R8", "clr/strobes on send",
            {irq_clr, req_o, rdy_o}, 3'b111);
        @(negedge clk);
        chk(tx_valid == 1'b0 && irq_clr == 1'b0, "R5", "single pulse",
            {tx_valid, irq_clr}, 0);
        sel_n = 1'b1;
    endtask

    task automatic finish_edge();
        @(negedge clk) dev_irq = 1'b1;
        @(negedge clk) dev_irq = 1'b0;
        chk(rx_mode && !req_o && rdy_o && !tx_valid && irq_clr, "R6",
            "switch to receive", {rx_mode, req_o, rdy_o, tx_valid, irq_clr}, 5'b10101);
        @(negedge clk);
        chk(irq_clr == 1'b0, "R8", "clr one cycle", irq_clr, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({link_on, req_o, rdy_o, rx_mode, tx_valid, irq_clr} == 0, "R1",
            "reset state", {link_on, req_o, rdy_o, rx_mode, tx_valid, irq_clr}, 0);
        rst_n = 1'b1;
        pulse(en_req);
        chk(link_on && req_o && rdy_o && !rx_mode, "R2", "enable",
            {link_on, req_o, rdy_o, rx_mode}, 4'b1110);

        // Table walk: full sequence with varied hold-back and a redundant enable (R9).
        for (int k = 0; k < 4; k++) begin
            if (STEPS[k][15]) pulse(en_req);
            step(int'(STEPS[k][14:8]), STEPS[k][7:0]);
        end
        finish_edge();
        // Edges in receive mode are not acted on.
        pulse(dev_irq);
        chk(!tx_valid && !irq_clr && rx_mode, "R6", "stay in receive",
            {tx_valid, irq_clr, rx_mode}, 1);

        // R7: disable tears down.
        pulse(dis_req);
        chk({link_on, req_o, rdy_o, rx_mode} == 0, "R7", "disable",
            {link_on, req_o, rdy_o, rx_mode}, 0);
        sel_n = 1'b0;
        @(negedge clk) dev_irq = 1'b1;
        @(negedge clk) dev_irq = 1'b0;
        repeat (2) begin
            @(negedge clk);
            chk(!tx_valid && !irq_clr, "R7", "edge ignored when off",
                {tx_valid, irq_clr}, 0);
        end
        // R9: redundant disable.
        pulse(dis_req);
        chk(!link_on, "R9", "redundant disable", link_on, 0);

        // R10: both requests while off.
        @(negedge clk) begin en_req = 1'b1; dis_req = 1'b1; end
        @(negedge clk) begin en_req = 1'b0; dis_req = 1'b0; end
        chk(!link_on, "R10", "disable wins when off", link_on, 0);

        // R2: fresh enable restarts at first command.
        pulse(en_req);
        // R5: second edge while held back is ignored.
        sel_n = 1'b1;
        @(negedge clk) dev_irq = 1'b1;
        @(negedge clk) dev_irq = 1'b0;
        @(negedge clk) dev_irq = 1'b1;
        @(negedge clk) dev_irq = 1'b0;
        sel_n = 1'b0;
        @(negedge clk);
        chk(tx_valid && tx_byte == 8'hF5, "R2", "restart at first", tx_byte, 8'hF5);
        begin
            int extra = 0;
            repeat (4) begin
                @(negedge clk);
                if (tx_valid) extra++;
            end
            chk(extra == 0, "R5", "edge during hold ignored", extra, 0);
        end
        step(0, 8'hF2);

        // R10: both requests while on.
        @(negedge clk) begin en_req = 1'b1; dis_req = 1'b1; end
        @(negedge clk) begin en_req = 1'b0; dis_req = 1'b0; end
        chk(!link_on && !req_o && !rdy_o, "R10", "disable wins when on",
            {link_on, req_o, rdy_o}, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                n_chk++;
                n_err++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule